// File: doc/BRIEF.md
# Operand Forwarding and Pipeline Hazard Controller

This block steers the hazard handling of a five-stage in-order pipeline: fetch, decode (where the register file is read), ALU (which also forms memory addresses), memory (which also serves as the second cycle of a multiply), and writeback (the only stage that commits to the register file). In every cycle it compares the two source register numbers of the instruction in decode with the destination registers of the three later stages. From that comparison it picks, for each operand, where the value should come from.

Most dependencies are hidden by forwarding. The exception is a result that only exists after the memory stage, such as a load or a multiply, when it sits in the ALU stage directly ahead of a consumer. In that case the block holds fetch and decode and inserts one bubble into the ALU stage. A branch that resolves taken in the ALU stage kills the two younger instructions in fetch and decode, and this kill overrides any stall raised in the same cycle.

All outputs are combinational from the current stage fields, except for one state bit. That bit records that a stall was raised in the previous cycle, which limits every stall to a single cycle.

Top module: `fwd_hazard_unit`

## Requirements
- R1: Each operand select uses the encoding 0 = register file, 1 = ALU stage, 2 = memory stage, 3 = writeback stage. When several stages match the source register, the priority is ALU stage over memory stage over writeback stage.
- R2: A stage counts as a match only while its write-enable input is 1. A stage whose write enable is 0 never selects itself, even when its destination equals the source register.
- R3: A source register written by the writeback stage in the same cycle selects 3 (writeback) and not 0, so the read and the write of one register in one cycle return the new value.
- R4: When the ALU-stage instruction has its late-result flag and write enable set, and its destination matches either source register, holdFetch, holdDecode and bubbleEx are all 1 in that same cycle.
- R5: The late-result flag raises no stall when the ALU-stage write enable is 0 or when neither source matches. In those cases holdFetch, holdDecode and bubbleEx stay 0.
- R6: A stall lasts exactly one cycle. In the cycle after holdFetch/holdDecode/bubbleEx were 1, they are 0 even if the load-use inputs are unchanged.
- R7: branchTaken = 1 drives flushFetch and flushDecode to 1 in the same cycle. With branchTaken = 0 both are 0.
- R8: A flush wins over a stall. With branchTaken = 1 and a load-use match, hold and bubble outputs are 0. Because no stall was raised, the same match in the following cycle without a branch does stall.
- R9: With the default configuration, register 0 is compared like any other register. With the zero-register option set, a source of register 0 always selects 0 and never causes a stall.
- R10: Right after reset, with all stage write enables and the branch input at 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| idRsA | input | RegAddrW | First source register of the decode-stage instruction |
| idRsB | input | RegAddrW | Second source register of the decode-stage instruction |
| exRd | input | RegAddrW | Destination register of the ALU-stage instruction |
| exWe | input | 1 | ALU-stage instruction writes a register |
| exLate | input | 1 | ALU-stage result is only ready after the memory stage (load or multiply) |
| memRd | input | RegAddrW | Destination register of the memory-stage instruction |
| memWe | input | 1 | Memory-stage instruction writes a register |
| wbRd | input | RegAddrW | Destination register of the writeback-stage instruction |
| wbWe | input | 1 | Writeback-stage instruction writes a register |
| branchTaken | input | 1 | Branch in the ALU stage resolved taken |
| fwdSelA | output | 2 | Value source for the first operand |
| fwdSelB | output | 2 | Value source for the second operand |
| holdFetch | output | 1 | Fetch keeps its contents this cycle |
| holdDecode | output | 1 | Decode keeps its contents this cycle |
| bubbleEx | output | 1 | A no-op enters the ALU stage next |
| flushFetch | output | 1 | Kill the instruction in fetch |
| flushDecode | output | 1 | Kill the instruction in decode |

## Verification
A taken branch and a load-use stall can coincide when the resolving branch sits in the ALU stage at the same time as a load whose destination the decode instruction reads. The bench provokes this with a vector that sets branchTaken together with a matching late result. It expects both flushes high and all hold and bubble outputs low. In the next cycle it repeats the match without the branch and expects the stall to appear, which shows that the suppressed stall left no trace in the one-cycle limiter. Long runs of random stage fields over a four-register range force frequent multi-stage matches, and these are judged against a priority model inside the bench.

// File: rtl/fwd_hazard_pkg.sv
package fwd_hazard_pkg;

  // Number of source operands read in decode
  localparam int NUM_SRC = 2;

  // Where an operand value is taken from
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_ALU     = 2'd1,
    SRC_MEM     = 2'd2,
    SRC_WB      = 2'd3
  } fwdSrc_e;

  // Datapath compare -> control: late-result match per operand
  typedef struct packed {
    logic [NUM_SRC-1:0] lateHit;
  } hazStrobe_t;

  // Control -> pipeline registers
  typedef struct packed {
    logic holdFront;
    logic bubble;
    logic killFront;
  } ctrlStrobe_t;

endpackage

// File: rtl/fwd_select_path.sv
module fwd_select_path
  import fwd_hazard_pkg::*;
#(
  parameter int RegAddrW         = 5,
  parameter bit ZeroRegHardwired = 1'b0
) (
  input  logic [NUM_SRC-1:0][RegAddrW-1:0] srcReg,
  input  logic [RegAddrW-1:0]              exRd,
  input  logic                             exWe,
  input  logic                             exLate,
  input  logic [RegAddrW-1:0]              memRd,
  input  logic                             memWe,
  input  logic [RegAddrW-1:0]              wbRd,
  input  logic                             wbWe,
  output fwdSrc_e [NUM_SRC-1:0]            fwdSel,
  output hazStrobe_t                       haz
);

  logic [NUM_SRC-1:0] lateHitVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic srcLive;
    logic hitEx;
    logic hitMem;
    logic hitWb;

    // Variant: register 0 either behaves normally or is a constant
    if (ZeroRegHardwired) begin : g_zero_const
      assign srcLive = |srcReg[i];
    end else begin : g_zero_plain
      assign srcLive = 1'b1;
    end

    assign hitEx  = srcLive && exWe  && (exRd  == srcReg[i]);
    assign hitMem = srcLive && memWe && (memRd == srcReg[i]);
    assign hitWb  = srcLive && wbWe  && (wbRd  == srcReg[i]);

    // Youngest producer wins
    assign fwdSel[i] = hitEx  ? SRC_ALU :
                       hitMem ? SRC_MEM :
                       hitWb  ? SRC_WB  : SRC_REGFILE;

    assign lateHitVec[i] = hitEx && exLate;
  end

  assign haz.lateHit = lateHitVec;

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import fwd_hazard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hazStrobe_t  haz,
  input  logic        branchTaken,
  output ctrlStrobe_t ctrl
);

  logic stallQ;
  logic stallNow;

  // A stall is dropped if one was raised last cycle (bubble already in ALU
  // stage) or if the decode instruction is being killed by a branch.
  assign stallNow = (|haz.lateHit) && !stallQ && !branchTaken;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stallQ <= 1'b0;
    else       stallQ <= stallNow;
  end

  always_comb begin
    ctrl.holdFront = stallNow;
    ctrl.bubble    = stallNow;
    ctrl.killFront = branchTaken;
  end

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_hazard_pkg::*;
#(
  parameter int RegAddrW         = 5,
  parameter bit ZeroRegHardwired = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [RegAddrW-1:0] idRsA,
  input  logic [RegAddrW-1:0] idRsB,
  input  logic [RegAddrW-1:0] exRd,
  input  logic                exWe,
  input  logic                exLate,
  input  logic [RegAddrW-1:0] memRd,
  input  logic                memWe,
  input  logic [RegAddrW-1:0] wbRd,
  input  logic                wbWe,
  input  logic                branchTaken,
  output logic [1:0]          fwdSelA,
  output logic [1:0]          fwdSelB,
  output logic                holdFetch,
  output logic                holdDecode,
  output logic                bubbleEx,
  output logic                flushFetch,
  output logic                flushDecode
);

  logic [NUM_SRC-1:0][RegAddrW-1:0] srcReg;
  fwdSrc_e [NUM_SRC-1:0]            fwdSel;
  hazStrobe_t                       haz;
  ctrlStrobe_t                      ctrl;

  assign srcReg = {idRsB, idRsA};

  fwd_select_path #(
    .RegAddrW        (RegAddrW),
    .ZeroRegHardwired(ZeroRegHardwired)
  ) selPath_i (
    .srcReg(srcReg),
    .exRd  (exRd),
    .exWe  (exWe),
    .exLate(exLate),
    .memRd (memRd),
    .memWe (memWe),
    .wbRd  (wbRd),
    .wbWe  (wbWe),
    .fwdSel(fwdSel),
    .haz   (haz)
  );

  hazard_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .haz        (haz),
    .branchTaken(branchTaken),
    .ctrl       (ctrl)
  );

  assign fwdSelA     = fwdSel[0];
  assign fwdSelB     = fwdSel[1];
  assign holdFetch   = ctrl.holdFront;
  assign holdDecode  = ctrl.holdFront;
  assign bubbleEx    = ctrl.bubble;
  assign flushFetch  = ctrl.killFront;
  assign flushDecode = ctrl.killFront;

endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int RegAddrW = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [RegAddrW-1:0] idRsA,
  input logic [RegAddrW-1:0] idRsB,
  input logic [RegAddrW-1:0] exRd,
  input logic                exWe,
  input logic                exLate,
  input logic [RegAddrW-1:0] memRd,
  input logic                memWe,
  input logic [1:0]          fwdSelA,
  input logic [1:0]          fwdSelB,
  input logic                holdFetch,
  input logic                holdDecode,
  input logic                bubbleEx,
  input logic                flushFetch
);

  // R4
  bubble_needs_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    bubbleEx |-> (exLate && exWe));

  // R6
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    bubbleEx |=> !bubbleEx);

  // R8
  flush_over_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushFetch |-> (!holdFetch && !holdDecode && !bubbleEx));

  // R2
  alu_sel_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA == 2'd1) |-> (exWe && (exRd == idRsA)));

  // R1
  mem_sel_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelB == 2'd2) |-> (memWe && (memRd == idRsB) && !(exWe && (exRd == idRsB))));

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.RegAddrW(RegAddrW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .idRsA     (idRsA),
  .idRsB     (idRsB),
  .exRd      (exRd),
  .exWe      (exWe),
  .exLate    (exLate),
  .memRd     (memRd),
  .memWe     (memWe),
  .fwdSelA   (fwdSelA),
  .fwdSelB   (fwdSelB),
  .holdFetch (holdFetch),
  .holdDecode(holdDecode),
  .bubbleEx  (bubbleEx),
  .flushFetch(flushFetch)
);

// File: tb/fwd_hazard_unit_tb_top.sv
module fwd_hazard_unit_tb_top;

  localparam int AW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rstN;
  logic [AW-1:0] idRsA, idRsB, exRd, memRd, wbRd;
  logic          exWe, exLate, memWe, wbWe, branchTaken;

  logic [1:0] selA0, selB0, selA1, selB1;
  logic hf0, hd0, bx0, ff0, fd0;
  logic hf1, hd1, bx1, ff1, fd1;

  fwd_hazard_unit #(.RegAddrW(AW), .ZeroRegHardwired(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .idRsA(idRsA), .idRsB(idRsB),
    .exRd(exRd), .exWe(exWe), .exLate(exLate),
    .memRd(memRd), .memWe(memWe), .wbRd(wbRd), .wbWe(wbWe),
    .branchTaken(branchTaken),
    .fwdSelA(selA0), .fwdSelB(selB0), .holdFetch(hf0), .holdDecode(hd0),
    .bubbleEx(bx0), .flushFetch(ff0), .flushDecode(fd0)
  );

  fwd_hazard_unit #(.RegAddrW(AW), .ZeroRegHardwired(1'b1)) dut_z_i (
    .clk(clk), .rstN(rstN), .idRsA(idRsA), .idRsB(idRsB),
    .exRd(exRd), .exWe(exWe), .exLate(exLate),
    .memRd(memRd), .memWe(memWe), .wbRd(wbRd), .wbWe(wbWe),
    .branchTaken(branchTaken),
    .fwdSelA(selA1), .fwdSelB(selB1), .holdFetch(hf1), .holdDecode(hd1),
    .bubbleEx(bx1), .flushFetch(ff1), .flushDecode(fd1)
  );

  int checks = 0;
  int errors = 0;

  // Packing: [8:7] selA, [6:5] selB, [4] holdFetch, [3] holdDecode,
  //          [2] bubbleEx, [1] flushFetch, [0] flushDecode
  logic [8:0] expQ[$];
  logic [8:0] expZQ[$];
  string      tagQ[$];
  logic       prevS  = 1'b0;
  logic       prevSZ = 1'b0;

  function automatic logic [1:0] pickSel(input logic zh, input logic [AW-1:0] rs,
      input logic [AW-1:0] er, input logic ew, input logic [AW-1:0] mr,
      input logic mw, input logic [AW-1:0] wr, input logic ww);
    if (zh && rs == '0)        return 2'd0;
    if (ew && er == rs)        return 2'd1;
    if (mw && mr == rs)        return 2'd2;
    if (ww && wr == rs)        return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [8:0] model(input logic zh, input logic prevStall,
      input logic [AW-1:0] ra, input logic [AW-1:0] rb,
      input logic [AW-1:0] er, input logic ew, input logic lt,
      input logic [AW-1:0] mr, input logic mw,
      input logic [AW-1:0] wr, input logic ww, input logic br);
    logic [1:0] sa, sb;
    logic hitA, hitB, st;
    sa   = pickSel(zh, ra, er, ew, mr, mw, wr, ww);
    sb   = pickSel(zh, rb, er, ew, mr, mw, wr, ww);
    hitA = ew && (er == ra) && !(zh && ra == '0);
    hitB = ew && (er == rb) && !(zh && rb == '0);
    st   = lt && (hitA || hitB) && !prevStall && !br;
    return {sa, sb, st, st, st, br, br};
  endfunction

  // Driver: applies one vector per cycle and queues the expected outputs
  task automatic drive(input string tag,
      input logic [AW-1:0] ra, input logic [AW-1:0] rb,
      input logic [AW-1:0] er, input logic ew, input logic lt,
      input logic [AW-1:0] mr, input logic mw,
      input logic [AW-1:0] wr, input logic ww, input logic br);
    logic [8:0] e, ez;
    @(posedge clk);
    #1;
    idRsA = ra; idRsB = rb; exRd = er; exWe = ew; exLate = lt;
    memRd = mr; memWe = mw; wbRd = wr; wbWe = ww; branchTaken = br;
    e  = model(1'b0, prevS,  ra, rb, er, ew, lt, mr, mw, wr, ww, br);
    ez = model(1'b1, prevSZ, ra, rb, er, ew, lt, mr, mw, wr, ww, br);
    prevS  = e[2];
    prevSZ = ez[2];
    expQ.push_back(e);
    expZQ.push_back(ez);
    tagQ.push_back(tag);
  endtask

  // Monitor: samples away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (tagQ.size() > 0) begin
        logic [8:0] e, ez, a, az;
        string t;
        e  = expQ.pop_front();
        ez = expZQ.pop_front();
        t  = tagQ.pop_front();
        a  = {selA0, selB0, hf0, hd0, bx0, ff0, fd0};
        az = {selA1, selB1, hf1, hd1, bx1, ff1, fd1};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s dut_i actual=%b expected=%b", t, a, e);
        end
        checks++;
        if (az !== ez) begin
          errors++;
          $display("FAIL %s dut_z_i actual=%b expected=%b", t, az, ez);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    idRsA = '0; idRsB = '0; exRd = '0; memRd = '0; wbRd = '0;
    exWe = 1'b0; exLate = 1'b0; memWe = 1'b0; wbWe = 1'b0; branchTaken = 1'b0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    drive("R10 idle after reset", 5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 5'd0, 0, 0);
    // R1 priority: all three stages write reg 5 -> ALU
    drive("R1 ALU over mem/wb",   5'd5, 5'd6, 5'd5, 1, 0, 5'd5, 1, 5'd5, 1, 0);
    // R1 mem over wb
    drive("R1 mem over wb",       5'd7, 5'd7, 5'd3, 1, 0, 5'd7, 1, 5'd7, 1, 0);
    // R3 same-cycle writeback
    drive("R3 wb same cycle",     5'd1, 5'd9, 5'd2, 1, 0, 5'd4, 1, 5'd9, 1, 0);
    // R2 ALU stage not writing
    drive("R2 ALU we low",        5'd5, 5'd5, 5'd5, 0, 1, 5'd5, 1, 5'd8, 1, 0);
    drive("R2 all we low",        5'd5, 5'd5, 5'd5, 0, 0, 5'd5, 0, 5'd5, 0, 0);
    // R4 load-use, then R6 limiter on the same inputs
    drive("R4 load-use on B",     5'd1, 5'd12, 5'd12, 1, 1, 5'd0, 0, 5'd0, 0, 0);
    drive("R6 no second stall",   5'd1, 5'd12, 5'd12, 1, 1, 5'd0, 0, 5'd0, 0, 0);
    drive("R6 stall after gap",   5'd1, 5'd12, 5'd12, 1, 1, 5'd0, 0, 5'd0, 0, 0);
    drive("R6 load in mem",       5'd1, 5'd12, 5'd0, 0, 0, 5'd12, 1, 5'd0, 0, 0);
    // R5 no stall cases
    drive("R5 late but we low",   5'd3, 5'd4, 5'd3, 0, 1, 5'd0, 0, 5'd0, 0, 0);
    drive("R5 late no match",     5'd3, 5'd4, 5'd6, 1, 1, 5'd0, 0, 5'd0, 0, 0);
    // R7 branch alone
    drive("R7 branch taken",      5'd3, 5'd4, 5'd6, 1, 0, 5'd0, 0, 5'd0, 0, 1);
    drive("R7 no branch",         5'd3, 5'd4, 5'd6, 1, 0, 5'd0, 0, 5'd0, 0, 0);
    // R8 branch and load-use together, then load-use alone
    drive("R8 flush beats stall", 5'd10, 5'd2, 5'd10, 1, 1, 5'd0, 0, 5'd0, 0, 1);
    drive("R8 stall next cycle",  5'd10, 5'd2, 5'd10, 1, 1, 5'd0, 0, 5'd0, 0, 0);
    drive("R8 clear",             5'd1, 5'd2, 5'd0, 0, 0, 5'd0, 0, 5'd0, 0, 0);
    // R9 register 0
    drive("R9 reg0 load-use",     5'd0, 5'd2, 5'd0, 1, 1, 5'd0, 1, 5'd0, 1, 0);
    drive("R9 reg0 mem/wb",       5'd0, 5'd0, 5'd3, 1, 0, 5'd0, 1, 5'd0, 1, 0);

    // R1 / R4 random: small register range forces collisions
    for (int k = 0; k < 400; k++) begin
      drive("R1 R4 random",
            AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
            AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)),
            AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 7) == 0));
    end

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule